// File: doc/BRIEF.md
# Software Nonvolatile Command Sequence Detector

This block watches the asynchronous SRAM bus of a nonvolatile SRAM and picks out a fixed series of six read addresses. When that series is presented, one read at a time, it issues a one-cycle pulse that starts a nonvolatile copy. A store copies the SRAM contents into the shadow array. A recall copies the shadow array back into the SRAM. The six reads remain ordinary SRAM reads. The array, the nonvolatile cells and the analog timing are outside this block. The copy engine is visible here only through a busy input.

The bus pins are brought into the clock domain through a small synchronizer. A step is sampled on each falling edge of chip enable. The five opening addresses are common to both commands, and the sixth address chooses between store and recall. A wrong address, a write, or a repeated strobe of the address just accepted throws the series away. While the copy engine is busy, the detector stays idle.

Top module: `nvseq_detect`

## Requirements
- R1: After a synchronous active-low reset, `store_go` and `recall_go` are low and the detector has no progress through the series.
- R2: Six read strobes at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0C63 (15-bit addresses), in that order, raise `recall_go` for exactly one clock cycle.
- R3: Six read strobes whose first five addresses are the same as in R2 and whose sixth is 0x0FC0 raise `store_go` for exactly one clock cycle.
- R4: A strobe at an address other than the expected next one abandons the series at any of the six steps. The steps that follow produce no pulse, and a complete series presented afterwards is recognised again.
- R5: A mismatching strobe whose address is 0x0E38 counts as the first step of a new series.
- R6: A write (chip enable and write enable both low) at any point in the series cancels it, and the rest of the series produces no pulse.
- R7: A strobe that repeats the address of the step just accepted aborts the series to idle, even when that address is 0x0E38.
- R8: Progress is made only on a high-to-low transition of chip enable. Address changes while chip enable stays low do not advance the series.
- R9: While `busy` is high, no strobe advances the detector and no pulse is issued. After busy clears, a full series is recognised.
- R10: `store_go` and `recall_go` are never high in the same cycle, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable from the SRAM bus, active low, asynchronous |
| we_n | input | 1 | Write enable from the SRAM bus, active low, asynchronous |
| addr | input | ADDR_W (15) | Address from the SRAM bus |
| busy | input | 1 | High while the nonvolatile engine is running a copy |
| store_go | output | 1 | One-cycle pulse that starts a store |
| recall_go | output | 1 | One-cycle pulse that starts a recall |

## Verification
The bench breaks the series at each of the six positions in turn and then completes it. A detector that forgot to drop its progress would fire on the leftover steps, and one that stuck after an abort would miss the clean series that follows. A repeat of the first address separates the two restart rules. A matcher that treated a double strobe as an ordinary restart would accept the next five addresses and fire, while one that ignored the first-address rule would miss a series that begins again mid-way. Writes in the middle of a series, addresses walked while chip enable stays low, and a full series presented under busy each target a detector that would fire when it must not.

// File: rtl/nvseq_pkg.sv
// Package: constants and helpers shared by the command sequence detector.
// Assumes a 15-bit address bus and a fixed six-step command series.
package nvseq_pkg;

    localparam int CMD_AW     = 15;
    localparam int SEQ_LEN    = 6;
    localparam int PREFIX_LEN = SEQ_LEN - 1;
    localparam int STEP_W     = $clog2(SEQ_LEN + 1);

    localparam logic [CMD_AW-1:0] STORE_LAST  = 15'h0FC0;
    localparam logic [CMD_AW-1:0] RECALL_LAST = 15'h0C63;

    // Address expected at a given position of the shared opening steps.
    function automatic logic [CMD_AW-1:0] prefix_addr(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd0:    prefix_addr = 15'h0E38;
            3'd1:    prefix_addr = 15'h31C7;
            3'd2:    prefix_addr = 15'h03E0;
            3'd3:    prefix_addr = 15'h3C1F;
            3'd4:    prefix_addr = 15'h303F;
            default: prefix_addr = '0;
        endcase
    endfunction

endpackage

// File: rtl/nvseq_sync.sv
// Module: nvseq_sync
// Brings a bundle of asynchronous bus pins into the clock domain through a
// chain of STAGES flops. Assumes that the bus holds the address stable around
// the chip-enable edge, so that all bits settle in the same cycle.
module nvseq_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability of the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/nvseq_strobe.sv
// Module: nvseq_strobe
// Turns the synchronized bus into events. It reports a strobe on each
// high-to-low transition of chip enable, and a write event when the
// chip-enable-and-write-enable-low condition begins. Assumes that inputs are
// already synchronous and that both enables idle high.
module nvseq_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s_n,
    input  logic we_s_n,
    output logic strobe,
    output logic wr_evt
);

    logic ce_d_n;
    logic wr_d;
    logic wr_now;

    assign wr_now = !ce_s_n && !we_s_n;

    // Remembers the previous enable levels so that edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d_n <= 1'b1;
            wr_d   <= 1'b0;
        end else begin
            ce_d_n <= ce_s_n;
            wr_d   <= wr_now;
        end
    end

    assign strobe = ce_d_n && !ce_s_n;
    assign wr_evt = wr_now && !wr_d;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe) else $error("double strobe cycle"); // R8

endmodule

// File: rtl/nvseq_match.sv
// Module: nvseq_match
// Tracks progress through the six-step series and issues the command pulses.
// It applies the abort rules: busy, write, double strobe and mismatch.
// Assumes one strobe per chip-enable fall and one write event per write.
module nvseq_match
    import nvseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              strobe,
    input  logic              wr_evt,
    input  logic              we_s_n,
    input  logic [CMD_AW-1:0] addr_s,
    output logic              store_go,
    output logic              recall_go
);

    logic [STEP_W-1:0] step_q, step_n;
    logic [CMD_AW-1:0] last_q, last_n;
    logic              store_q, store_n;
    logic              recall_q, recall_n;

    // Works out the next step count and any pulse for this cycle.
    always_comb begin
        step_n   = step_q;
        last_n   = last_q;
        store_n  = 1'b0;
        recall_n = 1'b0;
        if (busy) begin
            step_n = '0;
        end else if (wr_evt || (strobe && !we_s_n)) begin
            step_n = '0;
        end else if (strobe) begin
            last_n = addr_s;
            if (step_q != '0 && addr_s == last_q) begin
                step_n = '0;
            end else if (step_q == STEP_W'(PREFIX_LEN)) begin
                step_n = '0;
                if (addr_s == STORE_LAST)            store_n  = 1'b1;
                else if (addr_s == RECALL_LAST)      recall_n = 1'b1;
                else if (addr_s == prefix_addr('0))  step_n   = STEP_W'(1);
            end else if (addr_s == prefix_addr(step_q)) begin
                step_n = step_q + STEP_W'(1);
            end else if (addr_s == prefix_addr('0)) begin
                step_n = STEP_W'(1);
            end else begin
                step_n = '0;
            end
        end
    end

    // Holds the progress, the last accepted address and the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            last_q   <= '0;
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            step_q   <= step_n;
            last_q   <= last_n;
            store_q  <= store_n;
            recall_q <= recall_n;
        end
    end

    assign store_go  = store_q;
    assign recall_go = recall_q;

    AST_EXCLUSIVE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_q && recall_q)) else $error("both pulses"); // R10
    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q || recall_q) |=> !(store_q || recall_q)) else $error("long pulse"); // R10
    AST_GO_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q || recall_q) |-> $past(step_q) == STEP_W'(PREFIX_LEN)) else $error("early pulse"); // R2
    AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step_q == '0 && !store_q && !recall_q)) else $error("busy ignored"); // R9
    AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> step_q == '0) else $error("write kept progress"); // R6
    AST_ADVANCE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q > $past(step_q)) |-> $past(strobe)) else $error("advance without strobe"); // R8

endmodule

// File: rtl/nvseq_detect.sv
// Module: nvseq_detect (top)
// Detects the six-read command series on an asynchronous SRAM bus and issues
// one-cycle store or recall start pulses. Assumes the bus idles with both
// enables high and that busy is synchronous to clk.
module nvseq_detect #(
    parameter int ADDR_W      = nvseq_pkg::CMD_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic              store_go,
    output logic              recall_go
);

    localparam int BUS_W = ADDR_W + 2;
    localparam logic [BUS_W-1:0] BUS_IDLE = {2'b11, {ADDR_W{1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              ce_s_n;
    logic              we_s_n;
    logic [ADDR_W-1:0] addr_s;
    logic              strobe;
    logic              wr_evt;

    nvseq_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, addr}),
        .q     (bus_s)
    );

    assign {ce_s_n, we_s_n, addr_s} = bus_s;

    nvseq_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_s_n (ce_s_n),
        .we_s_n (we_s_n),
        .strobe (strobe),
        .wr_evt (wr_evt)
    );

    nvseq_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .strobe    (strobe),
        .wr_evt    (wr_evt),
        .we_s_n    (we_s_n),
        .addr_s    (addr_s),
        .store_go  (store_go),
        .recall_go (recall_go)
    );

endmodule

// File: tb/nvseq_detect_test.sv
// Scoreboard bench: driver tasks push expected commands, a monitor pops them.
module nvseq_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int KIND_STORE  = 1;
    localparam int KIND_RECALL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic        busy = 1'b0;
    logic        store_go;
    logic        recall_go;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    string req_q[$];
    string cur_req = "R1";
    bit done = 1'b0;

    logic [14:0] seq [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63};
    localparam logic [14:0] STORE_END = 15'h0FC0;
    localparam logic [14:0] BAD = 15'h1234;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvseq_detect uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .busy(busy), .store_go(store_go), .recall_go(recall_go)
    );

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [14:0] a);
        addr = a; we_n = 1'b1;
        cycles(2); ce_n = 1'b0;
        cycles(4); ce_n = 1'b1;
        cycles(3);
    endtask

    task automatic bus_write(input logic [14:0] a);
        addr = a; cycles(2);
        ce_n = 1'b0; cycles(1); we_n = 1'b0;
        cycles(3); we_n = 1'b1; cycles(1); ce_n = 1'b1;
        cycles(3);
    endtask

    task automatic expect_cmd(input int kind, input string req);
        exp_q.push_back(kind);
        req_q.push_back(req);
    endtask

    task automatic drained(input string req);
        cycles(12);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: pending expected pulses actual=%0d expected=0", req, exp_q.size());
            exp_q.delete(); req_q.delete();
        end
    endtask

    task automatic full_series(input int kind);
        for (int i = 0; i < 5; i++) bus_read(seq[i]);
        bus_read(kind == KIND_STORE ? STORE_END : seq[5]);
    endtask

    // Monitor: every pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && !done && (store_go || recall_go)) begin
            int got;
            got = store_go ? KIND_STORE : KIND_RECALL;
            tests++;
            if (store_go && recall_go) begin
                fails++;
                $display("FAIL R10: both pulses actual=3 expected=1 or 2");
            end else if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected pulse actual=%0d expected=none", cur_req, got);
            end else begin
                int e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (e != got) begin
                    fails++;
                    $display("FAIL %s: pulse kind actual=%0d expected=%0d", r, got, e);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(3);
        // R1: outputs low in reset and just after it
        tests++;
        if (store_go !== 1'b0 || recall_go !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset outputs actual=%b%b expected=00", store_go, recall_go);
        end
        rst_n = 1'b1;
        cycles(3);
        tests++;
        if (store_go !== 1'b0 || recall_go !== 1'b0) begin
            fails++;
            $display("FAIL R1: post-reset outputs actual=%b%b expected=00", store_go, recall_go);
        end

        // R2: recall series
        cur_req = "R2"; expect_cmd(KIND_RECALL, "R2");
        full_series(KIND_RECALL); drained("R2");

        // R3: store series
        cur_req = "R3"; expect_cmd(KIND_STORE, "R3");
        full_series(KIND_STORE); drained("R3");

        // R4: wrong address at each step, then the rest; then a clean series
        for (int k = 0; k < 6; k++) begin
            cur_req = "R4";
            for (int i = 0; i < 6; i++) bus_read(i == k ? BAD : seq[i]);
            drained("R4");
            expect_cmd(KIND_RECALL, "R4");
            full_series(KIND_RECALL); drained("R4");
        end

        // R5: mismatch equal to the first address restarts as step one
        cur_req = "R5"; expect_cmd(KIND_RECALL, "R5");
        bus_read(seq[0]); bus_read(seq[1]);
        full_series(KIND_RECALL); drained("R5");

        // R6: write in the middle cancels
        cur_req = "R6";
        bus_read(seq[0]); bus_read(seq[1]); bus_read(seq[2]);
        bus_write(seq[3]);
        bus_read(seq[3]); bus_read(seq[4]); bus_read(seq[5]);
        drained("R6");

        // R7: repeat of the accepted address aborts (later step)
        cur_req = "R7";
        bus_read(seq[0]); bus_read(seq[1]); bus_read(seq[1]);
        for (int i = 2; i < 6; i++) bus_read(seq[i]);
        drained("R7");
        // R7: repeat of the first address aborts rather than restarting
        bus_read(seq[0]); bus_read(seq[0]);
        for (int i = 1; i < 6; i++) bus_read(seq[i]);
        drained("R7");

        // R8: addresses walked with chip enable held low do not advance
        cur_req = "R8";
        addr = BAD; cycles(2); ce_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cycles(4); addr = seq[i];
        end
        cycles(4); ce_n = 1'b1; cycles(3);
        drained("R8");

        // R9: busy blocks detection, then a store is recognised
        cur_req = "R9";
        busy = 1'b1;
        full_series(KIND_RECALL);
        drained("R9");
        busy = 1'b0; cycles(2);
        expect_cmd(KIND_STORE, "R9");
        full_series(KIND_STORE); drained("R9");

        // R10: back-to-back commands each give one pulse
        cur_req = "R10";
        expect_cmd(KIND_RECALL, "R10"); expect_cmd(KIND_STORE, "R10");
        full_series(KIND_RECALL); full_series(KIND_STORE);
        drained("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule